// File: doc/BRIEF.md
# Saturating half-word arithmetic shifter

This block shifts one 16-bit half of a 32-bit value operand by a signed amount taken from a count operand. It serves a datapath whose 32-bit registers are also read and written as two 16-bit halves. The sign of the count sets the direction. A positive count shifts left. A negative count gives an arithmetic right shift by the count's magnitude.

The 16-bit result is merged into one half of a 32-bit destination word. The caller supplies the prior destination contents on `dst_i`, and the block returns the full word with the untouched half kept. When saturation is enabled, a left shift that overflows is clamped to the largest positive or most negative value, and a flag reports the clamp.

Each accepted operation is registered on a rising clock edge. The block has a one-cycle latency and can take a new operation on every cycle.

Top module: `half_ashift_sat`

## Requirements
- R1: A synchronous reset (`rst`=1 at a rising edge) clears `res_o`, `ovf_o` and `res_vld` to 0.
- R2: The shift amount is bits [5:0] of `cnt_i`, read as a two's-complement number from -32 to +31. Bits [31:6] of `cnt_i` have no effect on the result.
- R3: A negative amount shifts the source half right arithmetically by its magnitude, and vacated bits take the source sign bit. A magnitude of 16 or more gives 0xFFFF for a negative source and 0x0000 otherwise.
- R4: An amount of zero passes the source half through unchanged, with `ovf_o`=0.
- R5: A positive amount shifts the source half left, filling with zeros. With `sat_en`=0, the low 16 bits of the shifted value are kept and `ovf_o`=0, so a shift of 16 or more gives 0x0000.
- R6: With `sat_en`=1, a left shift whose exact result falls outside -32768..32767 gives 0x7FFF for a non-negative source or 0x8000 for a negative source, and sets `ovf_o`=1. Shifts whose result fits give the exact value with `ovf_o`=0.
- R7: Right-shift results do not depend on `sat_en`, and a right shift never sets `ovf_o`.
- R8: `src_hi`=1 selects `val_i[31:16]` as the source half, and `src_hi`=0 selects `val_i[15:0]`. This choice is independent of the destination half.
- R9: `dst_hi`=1 writes the result to `res_o[31:16]` and passes `dst_i[15:0]` to `res_o[15:0]`. `dst_hi`=0 writes the result to `res_o[15:0]` and passes `dst_i[31:16]` to `res_o[31:16]`.
- R10: When `in_valid`=1 at a rising edge, `res_o` and `ovf_o` take the new result and `res_vld` is 1 during the following cycle. When `in_valid`=0, `res_vld` goes to 0 and `res_o` and `ovf_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation accepted at this edge |
| val_i | input | 32 | Value operand holding both source halves |
| cnt_i | input | 32 | Count operand; bits [5:0] hold the signed amount |
| dst_i | input | 32 | Prior destination contents |
| src_hi | input | 1 | 1 = source is the high half of `val_i` |
| dst_hi | input | 1 | 1 = result goes to the high half of `res_o` |
| sat_en | input | 1 | 1 = clamp left-shift overflow |
| res_o | output | 32 | Merged destination word |
| ovf_o | output | 1 | Saturation occurred on the registered result |
| res_vld | output | 1 | `res_o` and `ovf_o` hold a new result |

## Verification
The bench builds the block with its default parameters: a 16-bit half and a 6-bit count. With these values the signed amount spans -32 to +31, so the bench can reach right shifts at, below and well beyond the half width, and left shifts that push every source bit out. The vectors cover the exact sign-fill results at -15, -16 and -32. They also cover the boundary between clamping and not clamping: 0xFFFF shifted left by 15 and 0xC000 shifted left by 1 both fit, while 0x4000 shifted left by 1 does not. Every source-half and destination-half pairing is driven, and so are counts whose upper bits are set.

// File: rtl/half_ashift_sat.sv
module half_ashift_sat #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2*W-1:0] val_i,
  input  logic [2*W-1:0] cnt_i,
  input  logic [2*W-1:0] dst_i,
  input  logic           src_hi,
  input  logic           dst_hi,
  input  logic           sat_en,
  output logic [2*W-1:0] res_o,
  output logic           ovf_o,
  output logic           res_vld
);
  localparam int EW = W + (1 << (CW - 1)) + 1;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]         src;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        mag;
  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] sh;
  logic [EW-W:0]        top;
  logic                 neg_cnt;
  logic                 wide;
  logic [W-1:0]         hres;

  wire unused_cnt = ^cnt_i[2*W-1:CW];

  assign src     = src_hi ? val_i[2*W-1:W] : val_i[W-1:0];
  assign cnt     = cnt_i[CW-1:0];
  assign neg_cnt = cnt[CW-1];
  assign mag     = CW'(-cnt);
  assign ext     = {{(EW-W){src[W-1]}}, src};
  assign sh      = neg_cnt ? (ext >>> mag) : (ext <<< cnt);
  assign top     = sh[EW-1:W-1];
  assign wide    = !neg_cnt && !((&top) || !(|top));
  assign hres    = (sat_en && wide) ? (src[W-1] ? NEG_MIN : POS_MAX) : sh[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      ovf_o   <= 1'b0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= in_valid;
      if (in_valid) begin
        res_o <= dst_hi ? {hres, dst_i[W-1:0]} : {dst_i[2*W-1:W], hres};
        ovf_o <= sat_en && wide;
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !ovf_o && !res_vld));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_vld);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_vld && $stable(res_o) && $stable(ovf_o)));

  a_r9_keep_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_hi) |=> res_o[W-1:0] == $past(dst_i[W-1:0]));

  a_r9_keep_high: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dst_hi) |=> res_o[2*W-1:W] == $past(dst_i[2*W-1:W]));

  a_r4_zero_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_i[CW-1:0] == '0 && !src_hi && !dst_hi)
      |=> (res_o[W-1:0] == $past(val_i[W-1:0]) && !ovf_o));

  a_r7_right_no_ovf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_i[CW-1]) |=> !ovf_o);

  a_r5_no_sat_no_ovf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en) |=> !ovf_o);

  a_r6_clamp_value: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!ovf_o ||
      (($past(dst_hi) ? res_o[2*W-1:W] : res_o[W-1:0]) == POS_MAX) ||
      (($past(dst_hi) ? res_o[2*W-1:W] : res_o[W-1:0]) == NEG_MIN)));
endmodule

// File: tb/tb_half_ashift_sat.sv
module tb_half_ashift_sat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] val_i = '0, cnt_i = '0, dst_i = '0;
  logic        src_hi = 1'b0, dst_hi = 1'b0, sat_en = 1'b0;
  logic [31:0] res_o;
  logic        ovf_o, res_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic        o;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  half_ashift_sat dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .val_i(val_i), .cnt_i(cnt_i),
    .dst_i(dst_i), .src_hi(src_hi), .dst_hi(dst_hi), .sat_en(sat_en),
    .res_o(res_o), .ovf_o(ovf_o), .res_vld(res_vld)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] v, input logic [31:0] c, input logic [31:0] d,
                       input bit sh, input bit dh, input bit sat, input string tag);
    exp_t e;
    longint s, p;
    int amt;
    logic [15:0] half;
    logic ov;
    s   = longint'($signed(sh ? v[31:16] : v[15:0]));
    amt = int'($signed(c[5:0]));
    ov  = 1'b0;
    if (amt < 0) p = s >>> (-amt);
    else p = s * (longint'(1) << amt);
    if (amt > 0 && sat && (p > 32767 || p < -32768)) begin
      ov = 1'b1;
      half = (s < 0) ? 16'h8000 : 16'h7FFF;
    end else begin
      half = p[15:0];
    end
    e.r = dh ? {half, d[15:0]} : {d[31:16], half};
    e.o = ov;
    e.tag = tag;
    @(negedge clk);
    val_i = v; cnt_i = c; dst_i = d; src_hi = sh; dst_hi = dh; sat_en = sat;
    in_valid = 1'b1;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected result", res_o, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_o == e.r, e.tag, res_o, e.r);
        check(ovf_o == e.o, {e.tag, " flag"}, {31'b0, ovf_o}, {31'b0, e.o});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(res_o == 32'h0 && !ovf_o && !res_vld, "R1 reset state",
          {res_o[31:2], ovf_o, res_vld}, 32'h0);

    drive(32'h0000_8001, 32'h0000_FFFF, 32'h0, 0, 0, 1, "R3 8001 by -1");
    drive(32'h0000_8003, 32'h0000_FFFF, 32'h0, 0, 0, 1, "R3 8003 by -1");
    drive(32'h0000_8007, 32'h0000_FFFF, 32'h0, 0, 0, 0, "R7 right no sat");
    drive(32'h0000_8001, 32'h0000_FFF1, 32'h0, 0, 0, 1, "R3 by -15");
    drive(32'h0000_8001, 32'h0000_FFF0, 32'h0, 0, 0, 1, "R3 by -16");
    drive(32'h0000_9001, 32'h0000_0020, 32'h0, 0, 0, 0, "R3 by -32");
    drive(32'h0000_7234, 32'h0000_FFF0, 32'h0, 0, 0, 1, "R3 pos by -16");
    drive(32'h0000_7234, 32'h0000_FFFC, 32'h0, 0, 0, 1, "R7 pos by -4 sat");
    drive(32'h0000_0001, 32'h0000_0000, 32'h0, 0, 0, 1, "R4 zero 0001");
    drive(32'h0000_8001, 32'h0000_0000, 32'h0, 0, 0, 0, "R4 zero 8001");
    drive(32'h0000_8001, 32'hFFFF_FFC0, 32'h0, 0, 0, 1, "R2 upper bits zero amt");
    drive(32'h0000_0003, 32'h1234_5641, 32'h0, 0, 0, 1, "R2 upper bits amt 1");
    drive(32'h0000_0003, 32'h0000_0002, 32'h0, 0, 0, 1, "R5 3 by 2");
    drive(32'h0000_4000, 32'h0000_0001, 32'h0, 0, 0, 0, "R5 wrap no sat");
    drive(32'h0000_8001, 32'h0000_0001, 32'h0, 0, 0, 0, "R5 neg wrap no sat");
    drive(32'h0000_0001, 32'h0000_0014, 32'h0, 0, 0, 0, "R5 by 20 no sat");
    drive(32'h0000_4000, 32'h0000_0001, 32'h0, 0, 0, 1, "R6 clamp pos");
    drive(32'h0000_8001, 32'h0000_0001, 32'h0, 0, 0, 1, "R6 clamp neg");
    drive(32'h0000_0001, 32'h0000_0014, 32'h0, 0, 0, 1, "R6 by 20 clamp");
    drive(32'h0000_FFFF, 32'h0000_001F, 32'h0, 0, 0, 1, "R6 -1 by 31 clamp");
    drive(32'h0000_0000, 32'h0000_001F, 32'h0, 0, 0, 1, "R6 zero by 31");
    drive(32'h0000_FFFF, 32'h0000_000F, 32'h0, 0, 0, 1, "R6 -1 by 15 fits");
    drive(32'h0000_C000, 32'h0000_0001, 32'h0, 0, 0, 1, "R6 C000 by 1 fits");
    drive(32'hA001_0000, 32'h0000_FFF1, 32'hA001_0000, 1, 0, 1, "R8 high src low dst");
    drive(32'h8001_1111, 32'h0000_FFFF, 32'h8001_2222, 1, 0, 1, "R8 high src");
    drive(32'h5555_8001, 32'h0000_FFFF, 32'hBEEF_CAFE, 0, 1, 1, "R9 low src high dst");
    drive(32'hE001_0000, 32'h0000_FFF0, 32'h1357_9BDF, 1, 1, 1, "R9 high to high");
    drive(32'h0001_0005, 32'h0000_0003, 32'hDEAD_BEEF, 1, 1, 0, "R9 keep low half");
    @(negedge clk);
    in_valid = 1'b0;
    val_i = 32'hFFFF_FFFF; cnt_i = 32'h0000_0001; sat_en = 1'b1;
    @(negedge clk);
    held = res_o;
    repeat (3) @(negedge clk);
    check(res_o == held && !res_vld, "R10 hold when idle", res_o, held);
    check(sb.size() == 0, "R10 all results seen", sb.size(), 32'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(res_o == 32'h0 && !ovf_o && !res_vld, "R1 reset after use",
          {res_o[31:2], ovf_o, res_vld}, 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule